// File: doc/BRIEF.md
# LCD Instruction Decoder and Address Counter

This block sits between the host bus front end of a character LCD controller and its display and glyph memories. It takes 8-bit instruction codes, works out which instruction each one is from the position of its most significant set bit, and keeps the mode state that the rest of the controller reads. This state covers the cursor direction, automatic display shift, the display, cursor and blink enables, the bus width, the line count and the font height.

A single 7-bit address counter points into either the 80-byte display RAM or the 64-byte glyph RAM, depending on which address-set instruction came last. Each data read or write issues one registered RAM strobe at the current address and then steps the counter. A horizontal display offset is tracked alongside the counter. A busy flag is held for a fixed number of oscillator cycles after every accepted operation, and anything that arrives while the flag is high is dropped and reported. The clear instruction fills the whole display RAM with the space code itself, one location per cycle.

Top module: `lcd_cmd_engine`

## Requirements
- R1: After reset the busy flag, ignored flag, RAM strobes, address counter (display RAM space) and display offset are all zero. The entry direction is increment, auto-shift is off, display, cursor and blink are off, the bus is 8 bits wide, one line is selected and the short font is selected.
- R2: The most significant set bit of an instruction code selects it, and the bits below the decoded fields are ignored. Bit 0 is clear, bit 1 is home, bit 2 is entry mode {dir=b1, shift=b0}, bit 3 is display control {display=b2, cursor=b1, blink=b0}, bit 4 is shift {display/cursor=b3, right=b2}, bit 5 is function {wide=b4, two-line=b3, tall=b2}, bit 6 is a glyph address in b5..b0, and bit 7 is a display address in b6..b0.
- R3: Clear writes 20h to display addresses 0 to 79 in ascending order, one per cycle, starting the cycle after acceptance. It also sets the counter to display address 0, sets the offset to 0 and forces the entry direction to increment.
- R4: Home sets the counter to display address 0 and the offset to 0 and writes no RAM.
- R5: After acceptance the busy flag stays high for exactly 410 cycles for clear and home, and for exactly 10 cycles for every other instruction and for each data read or write.
- R6: An instruction or data strobe that arrives while busy is high changes no state and issues no RAM access. The ignored output is high during the following cycle.
- R7: An accepted data write raises ram_we_o for one cycle, starting the cycle after acceptance, with the counter's old address, the current space (ram_cg_o=1 for glyph RAM) and the write data. The counter then moves by one in the entry direction, wrapping 79↔0 in display space and 63↔0 in glyph space.
- R8: An accepted data read raises ram_re_o for one cycle with the counter's old address and space, and the counter then steps as it does for a write.
- R9: When auto-shift is on, each write to display RAM also moves the offset: by +1 when the direction is increment and by -1 when it is decrement. Glyph writes leave the offset unchanged.
- R10: A shift instruction with b3=0 moves the counter (+1 when b2=1, -1 when b2=0, wrapping as in R7). With b3=1 it changes the offset instead (-1 when b2=1, +1 when b2=0) and leaves the counter alone.
- R11: The display offset wraps modulo 40 in two-line mode and modulo 80 in one-line mode.
- R12: A glyph address set selects glyph space with a 6-bit address, and a display address set selects display space with a 7-bit address. Later data accesses go to the selected space.
- R13: The display control and function instructions load their bits into the matching mode outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle instruction strobe |
| cmd_code_i | input | 8 | Instruction code |
| dat_wr_i | input | 1 | One-cycle data write strobe |
| dat_rd_i | input | 1 | One-cycle data read strobe |
| dat_wdata_i | input | 8 | Data to write |
| busy_o | output | 1 | Operation in progress |
| ignored_o | output | 1 | A strobe was dropped in the previous cycle |
| ac_o | output | 7 | Address counter |
| disp_ofs_o | output | 7 | Display shift offset |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_cg_o | output | 1 | Access targets glyph RAM |
| ram_addr_o | output | 7 | RAM address |
| ram_wdata_o | output | 8 | RAM write data |
| ent_inc_o | output | 1 | Entry direction is increment |
| ent_shift_o | output | 1 | Auto display shift on write |
| disp_on_o | output | 1 | Display enable |
| cur_on_o | output | 1 | Cursor enable |
| blink_on_o | output | 1 | Blink enable |
| bus_wide_o | output | 1 | 8-bit bus selected |
| two_line_o | output | 1 | Two-line mode |
| tall_font_o | output | 1 | Tall font selected |

## Verification
Writes and reads are driven in increment and decrement order and in both spaces, at the last address and at address zero, so that a wrong wrap point or a wrong space shows up as a mismatch in address or space. The offset is walked across zero in one-line and two-line modes to separate the 40 and 80 limits, and auto-shift writes to display and glyph space show that only display writes move it. Codes carrying stray low bits (3Bh, 03h, 1Fh) confirm that decoding depends only on the leading one. A second strobe issued during the busy window confirms that dropped requests leave the counter untouched.

// File: rtl/lcd_cmd_pkg.sv
// Shared types and helpers for the LCD instruction engine.
// Assumes a 7-bit address counter and wrap limits no larger than 127.
package lcd_cmd_pkg;

    localparam int ADDR_W = 7;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DISP,
        OP_SHIFT,
        OP_FUNC,
        OP_CGADDR,
        OP_DDADDR
    } op_e;

    // Step up by one inside [0, lim); anything at or past the top goes to 0.
    function automatic logic [ADDR_W-1:0] wrap_up(input logic [ADDR_W-1:0] v,
                                                   input logic [ADDR_W-1:0] lim);
        return (v >= lim - 7'd1) ? 7'd0 : v + 7'd1;
    endfunction

    // Step down by one inside [0, lim); zero or an out-of-range value goes to lim-1.
    function automatic logic [ADDR_W-1:0] wrap_dn(input logic [ADDR_W-1:0] v,
                                                   input logic [ADDR_W-1:0] lim);
        return (v == 7'd0 || v >= lim) ? lim - 7'd1 : v - 7'd1;
    endfunction

endpackage

// File: rtl/lcd_cmd_decode.sv
// Leading-one instruction decoder.
// Finds the most significant set bit of the code and maps it to an operation.
// Assumes: purely combinational; an all-zero code decodes to OP_NONE.
module lcd_cmd_decode
    import lcd_cmd_pkg::*;
(
    input  logic [7:0] code_i,
    output op_e        op_o
);

    logic [2:0] lead;
    logic       any_set;

    // Scan upward so the highest set bit wins.
    always_comb begin
        lead    = 3'd0;
        any_set = 1'b0;
        for (int b = 0; b < 8; b++) begin
            if (code_i[b]) begin
                lead    = 3'(b);
                any_set = 1'b1;
            end
        end
    end

    // Map the bit position to an operation.
    always_comb begin
        if (!any_set) begin
            op_o = OP_NONE;
        end else begin
            case (lead)
                3'd0:    op_o = OP_CLEAR;
                3'd1:    op_o = OP_HOME;
                3'd2:    op_o = OP_ENTRY;
                3'd3:    op_o = OP_DISP;
                3'd4:    op_o = OP_SHIFT;
                3'd5:    op_o = OP_FUNC;
                3'd6:    op_o = OP_CGADDR;
                default: op_o = OP_DDADDR;
            endcase
        end
    end

endmodule

// File: rtl/lcd_busy_timer.sv
// Busy timer: counts down a fixed execution time in oscillator cycles.
// Assumes start_i is only raised while idle; busy_o is high while the count is non-zero.
module lcd_busy_timer #(
    parameter int LONG_CYC  = 410,
    parameter int SHORT_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic long_i,
    output logic busy_o
);

    localparam int CW = $clog2(LONG_CYC + 1);

    logic [CW-1:0] cnt;

    // Load the execution time on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_i) begin
            cnt <= long_i ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy_o = (cnt != '0);

    assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_o);

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

endmodule

// File: rtl/lcd_addr_ctrl.sv
// Address counter, display offset and RAM strobe generator.
// Holds one counter for two RAM spaces, steps it on data accesses and cursor moves,
// tracks the display offset, and runs the space-code fill for clear.
// Assumes at most one request input is high per cycle and none arrive during a fill.
module lcd_addr_ctrl
    import lcd_cmd_pkg::*;
#(
    parameter int DD_DEPTH = 80,
    parameter int CG_DEPTH = 64,
    parameter int LINE_LEN = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              home_i,
    input  logic              cg_set_i,
    input  logic              dd_set_i,
    input  logic [ADDR_W-1:0] set_val_i,
    input  logic              cur_move_i,
    input  logic              disp_shift_i,
    input  logic              right_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [7:0]        wdata_i,
    input  logic              inc_i,
    input  logic              shift_en_i,
    input  logic              two_line_i,
    output logic [ADDR_W-1:0] ac_o,
    output logic [ADDR_W-1:0] ofs_o,
    output logic              ram_we_o,
    output logic              ram_re_o,
    output logic              ram_cg_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [7:0]        ram_wdata_o
);

    localparam logic [ADDR_W-1:0] DD_LIM  = ADDR_W'(DD_DEPTH);
    localparam logic [ADDR_W-1:0] CG_LIM  = ADDR_W'(CG_DEPTH);
    localparam logic [ADDR_W-1:0] L2_LIM  = ADDR_W'(LINE_LEN);
    localparam logic [ADDR_W-1:0] CG_MASK = CG_LIM - 7'd1;
    localparam logic [7:0]        SPACE   = 8'h20;

    logic [ADDR_W-1:0] ac, ofs, fill_idx, ac_lim, ofs_lim;
    logic              ac_cg, fill_on, ofs_step, ofs_up;

    assign ac_lim  = ac_cg ? CG_LIM : DD_LIM;
    assign ofs_lim = two_line_i ? L2_LIM : DD_LIM;

    // Decide whether and which way the display offset moves this cycle.
    always_comb begin
        ofs_step = 1'b0;
        ofs_up   = 1'b0;
        if (disp_shift_i) begin
            ofs_step = 1'b1;
            ofs_up   = !right_i;
        end else if (wr_i && shift_en_i && !ac_cg) begin
            ofs_step = 1'b1;
            ofs_up   = inc_i;
        end
    end

    // Address counter and its space select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac    <= '0;
            ac_cg <= 1'b0;
        end else if (clear_i || home_i) begin
            ac    <= '0;
            ac_cg <= 1'b0;
        end else if (cg_set_i) begin
            ac    <= set_val_i & CG_MASK;
            ac_cg <= 1'b1;
        end else if (dd_set_i) begin
            ac    <= set_val_i;
            ac_cg <= 1'b0;
        end else if (wr_i || rd_i) begin
            ac <= inc_i ? wrap_up(ac, ac_lim) : wrap_dn(ac, ac_lim);
        end else if (cur_move_i) begin
            ac <= right_i ? wrap_up(ac, ac_lim) : wrap_dn(ac, ac_lim);
        end
    end

    // Display shift offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs <= '0;
        end else if (clear_i || home_i) begin
            ofs <= '0;
        end else if (ofs_step) begin
            ofs <= ofs_up ? wrap_up(ofs, ofs_lim) : wrap_dn(ofs, ofs_lim);
        end
    end

    // Registered RAM strobes: clear fill first, then data write, then data read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o    <= 1'b0;
            ram_re_o    <= 1'b0;
            ram_cg_o    <= 1'b0;
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
            fill_on     <= 1'b0;
            fill_idx    <= '0;
        end else begin
            ram_we_o <= 1'b0;
            ram_re_o <= 1'b0;
            if (clear_i) begin
                ram_we_o    <= 1'b1;
                ram_cg_o    <= 1'b0;
                ram_addr_o  <= '0;
                ram_wdata_o <= SPACE;
                fill_on     <= 1'b1;
                fill_idx    <= 7'd1;
            end else if (fill_on) begin
                ram_we_o    <= 1'b1;
                ram_cg_o    <= 1'b0;
                ram_addr_o  <= fill_idx;
                ram_wdata_o <= SPACE;
                fill_idx    <= fill_idx + 7'd1;
                if (fill_idx == DD_LIM - 7'd1) begin
                    fill_on <= 1'b0;
                end
            end else if (wr_i) begin
                ram_we_o    <= 1'b1;
                ram_cg_o    <= ac_cg;
                ram_addr_o  <= ac;
                ram_wdata_o <= wdata_i;
            end else if (rd_i) begin
                ram_re_o   <= 1'b1;
                ram_cg_o   <= ac_cg;
                ram_addr_o <= ac;
            end
        end
    end

    assign ac_o  = ac;
    assign ofs_o = ofs;

    assert_ac_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_i || rd_i || cur_move_i) |-> ac < ac_lim);

    assert_ofs_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ofs_step) |-> ofs < ofs_lim);

    assert_fill_space_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_on |=> ram_we_o && !ram_cg_o && ram_wdata_o == SPACE);

    assert_fill_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> ram_we_o && ram_addr_o == '0);

endmodule

// File: rtl/lcd_cmd_engine.sv
// LCD instruction engine top level.
// Accepts instruction and data strobes, decodes instructions, keeps the mode
// registers and drives the address controller and busy timer.
// Assumes one-cycle strobes; if several strobes arrive together the instruction wins, then write, then read.
module lcd_cmd_engine
    import lcd_cmd_pkg::*;
#(
    parameter int DD_DEPTH  = 80,
    parameter int CG_DEPTH  = 64,
    parameter int LINE_LEN  = 40,
    parameter int LONG_CYC  = 410,
    parameter int SHORT_CYC = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid_i,
    input  logic [7:0] cmd_code_i,
    input  logic       dat_wr_i,
    input  logic       dat_rd_i,
    input  logic [7:0] dat_wdata_i,
    output logic       busy_o,
    output logic       ignored_o,
    output logic [6:0] ac_o,
    output logic [6:0] disp_ofs_o,
    output logic       ram_we_o,
    output logic       ram_re_o,
    output logic       ram_cg_o,
    output logic [6:0] ram_addr_o,
    output logic [7:0] ram_wdata_o,
    output logic       ent_inc_o,
    output logic       ent_shift_o,
    output logic       disp_on_o,
    output logic       cur_on_o,
    output logic       blink_on_o,
    output logic       bus_wide_o,
    output logic       two_line_o,
    output logic       tall_font_o
);

    op_e  op;
    logic busy, req_any, cmd_go, wr_go, rd_go, start;
    logic clear_go, home_go, entry_go, disp_go, shift_go, func_go, cg_go, dd_go;

    lcd_cmd_decode u_decode (
        .code_i (cmd_code_i),
        .op_o   (op)
    );

    // Accept a request only when idle and out of reset.
    assign req_any = cmd_valid_i | dat_wr_i | dat_rd_i;
    assign cmd_go  = rst_n & !busy & cmd_valid_i;
    assign wr_go   = rst_n & !busy & !cmd_valid_i & dat_wr_i;
    assign rd_go   = rst_n & !busy & !cmd_valid_i & !dat_wr_i & dat_rd_i;

    assign clear_go = cmd_go && op == OP_CLEAR;
    assign home_go  = cmd_go && op == OP_HOME;
    assign entry_go = cmd_go && op == OP_ENTRY;
    assign disp_go  = cmd_go && op == OP_DISP;
    assign shift_go = cmd_go && op == OP_SHIFT;
    assign func_go  = cmd_go && op == OP_FUNC;
    assign cg_go    = cmd_go && op == OP_CGADDR;
    assign dd_go    = cmd_go && op == OP_DDADDR;

    assign start = (cmd_go && op != OP_NONE) || wr_go || rd_go;

    lcd_busy_timer #(
        .LONG_CYC  (LONG_CYC),
        .SHORT_CYC (SHORT_CYC)
    ) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .long_i  (clear_go | home_go),
        .busy_o  (busy)
    );

    lcd_addr_ctrl #(
        .DD_DEPTH (DD_DEPTH),
        .CG_DEPTH (CG_DEPTH),
        .LINE_LEN (LINE_LEN)
    ) u_addr (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear_go),
        .home_i       (home_go),
        .cg_set_i     (cg_go),
        .dd_set_i     (dd_go),
        .set_val_i    (cmd_code_i[6:0]),
        .cur_move_i   (shift_go & !cmd_code_i[3]),
        .disp_shift_i (shift_go & cmd_code_i[3]),
        .right_i      (cmd_code_i[2]),
        .wr_i         (wr_go),
        .rd_i         (rd_go),
        .wdata_i      (dat_wdata_i),
        .inc_i        (ent_inc_o),
        .shift_en_i   (ent_shift_o),
        .two_line_i   (two_line_o),
        .ac_o         (ac_o),
        .ofs_o        (disp_ofs_o),
        .ram_we_o     (ram_we_o),
        .ram_re_o     (ram_re_o),
        .ram_cg_o     (ram_cg_o),
        .ram_addr_o   (ram_addr_o),
        .ram_wdata_o  (ram_wdata_o)
    );

    // Mode registers loaded by entry, display control and function instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_inc_o   <= 1'b1;
            ent_shift_o <= 1'b0;
            disp_on_o   <= 1'b0;
            cur_on_o    <= 1'b0;
            blink_on_o  <= 1'b0;
            bus_wide_o  <= 1'b1;
            two_line_o  <= 1'b0;
            tall_font_o <= 1'b0;
        end else begin
            if (clear_go) begin
                ent_inc_o <= 1'b1;
            end
            if (entry_go) begin
                ent_inc_o   <= cmd_code_i[1];
                ent_shift_o <= cmd_code_i[0];
            end
            if (disp_go) begin
                disp_on_o  <= cmd_code_i[2];
                cur_on_o   <= cmd_code_i[1];
                blink_on_o <= cmd_code_i[0];
            end
            if (func_go) begin
                bus_wide_o  <= cmd_code_i[4];
                two_line_o  <= cmd_code_i[3];
                tall_font_o <= cmd_code_i[2];
            end
        end
    end

    // Flag a dropped request one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ignored_o <= 1'b0;
        end else begin
            ignored_o <= req_any & busy;
        end
    end

    assign busy_o = busy;

    assert_ignore_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ignored_o |-> $past(busy));

    assert_home_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(home_go) |-> !ram_we_o && ac_o == '0 && disp_ofs_o == '0);

    assert_clear_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_go) |-> ac_o == '0 && disp_ofs_o == '0 && ent_inc_o);

endmodule

// File: tb/lcd_cmd_engine_bench.sv
module lcd_cmd_engine_bench;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       cmd_valid_i = 1'b0, dat_wr_i = 1'b0, dat_rd_i = 1'b0;
    logic [7:0] cmd_code_i = '0, dat_wdata_i = '0;
    logic       busy_o, ignored_o, ram_we_o, ram_re_o, ram_cg_o;
    logic [6:0] ac_o, disp_ofs_o, ram_addr_o;
    logic [7:0] ram_wdata_o;
    logic       ent_inc_o, ent_shift_o, disp_on_o, cur_on_o, blink_on_o;
    logic       bus_wide_o, two_line_o, tall_font_o;

    lcd_cmd_engine u_lcd_cmd_engine (.*);

    typedef struct {
        logic       rd;
        logic       cg;
        logic [6:0] addr;
        logic [7:0] data;
        string      req;
    } ev_t;

    ev_t exp_q[$];
    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: pop one expected RAM access per observed strobe.
    always @(negedge clk) begin
        ev_t e;
        if (rst_n && (ram_we_o || ram_re_o)) begin
            if (exp_q.size() == 0) begin
                n_vec++;
                n_bad++;
                $display("FAIL R4/R6 unexpected RAM access: actual addr %0h expected none", ram_addr_o);
            end else begin
                e = exp_q.pop_front();
                check(e.req, {ram_re_o, ram_cg_o, ram_addr_o}, {e.rd, e.cg, e.addr}, "rd/space/addr");
                if (!e.rd) check(e.req, ram_wdata_o, e.data, "wdata");
            end
        end
    end

    // kind: 0 instruction, 1 write, 2 read
    task automatic pulse(input int kind, input logic [7:0] v);
        @(negedge clk);
        if (kind == 0) begin cmd_valid_i = 1'b1; cmd_code_i = v; end
        if (kind == 1) begin dat_wr_i = 1'b1; dat_wdata_i = v; end
        if (kind == 2) dat_rd_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        dat_wr_i    = 1'b0;
        dat_rd_i    = 1'b0;
    endtask

    task automatic busy_len(input string req, input int exp);
        int n = 0;
        while (busy_o && n < 2000) begin
            n++;
            @(negedge clk);
        end
        check(req, n, exp, "busy cycles");
    endtask

    task automatic cmd(input logic [7:0] c, input int exp_busy, input string req);
        pulse(0, c);
        busy_len(req, exp_busy);
    endtask

    task automatic wr(input logic [7:0] d, input logic cg, input logic [6:0] a, input string req);
        exp_q.push_back('{1'b0, cg, a, d, req});
        pulse(1, d);
        busy_len(req, 10);
    endtask

    task automatic rd(input logic cg, input logic [6:0] a, input string req);
        exp_q.push_back('{1'b1, cg, a, 8'h00, req});
        pulse(2, 8'h00);
        busy_len(req, 10);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {busy_o, ignored_o, ram_we_o, ram_re_o}, 0, "flags");
        check("R1", ac_o, 0, "ac");
        check("R1", disp_ofs_o, 0, "offset");
        check("R1", {ent_inc_o, ent_shift_o, disp_on_o, cur_on_o, blink_on_o,
                     bus_wide_o, two_line_o, tall_font_o}, 8'b1000_0100, "modes");

        // R7 write at 0, R5 short busy
        wr(8'h41, 1'b0, 7'd0, "R7");
        check("R7", ac_o, 1, "ac after write");

        // R13 / R2 function set with stray low bits
        cmd(8'h3B, 10, "R5");
        check("R13", {bus_wide_o, two_line_o, tall_font_o}, 3'b110, "function bits");
        cmd(8'h0F, 10, "R13");
        check("R13", {disp_on_o, cur_on_o, blink_on_o}, 3'b111, "display bits");
        cmd(8'h0C, 10, "R13");
        check("R13", {disp_on_o, cur_on_o, blink_on_o}, 3'b100, "display bits");

        // R6 strobe during busy
        exp_q.push_back('{1'b0, 1'b0, 7'd1, 8'h42, "R6"});
        pulse(1, 8'h42);
        dat_wr_i = 1'b1; dat_wdata_i = 8'h43;
        @(negedge clk);
        dat_wr_i = 1'b0;
        check("R6", ignored_o, 1, "ignored flag");
        busy_len("R6", 9);
        check("R6", ac_o, 2, "ac after dropped write");

        // R7 display wrap up and down
        cmd(8'hCF, 10, "R12");
        wr(8'h5A, 1'b0, 7'd79, "R7");
        check("R7", ac_o, 0, "display wrap up");
        cmd(8'h04, 10, "R7");
        wr(8'h11, 1'b0, 7'd0, "R7");
        check("R7", ac_o, 79, "display wrap down");

        // R8 read
        cmd(8'h06, 10, "R8");
        cmd(8'h85, 10, "R8");
        rd(1'b0, 7'd5, "R8");
        check("R8", ac_o, 6, "ac after read");

        // R12 glyph space, R7 glyph wrap
        cmd(8'h7F, 10, "R12");
        check("R12", ac_o, 63, "glyph address");
        wr(8'h1F, 1'b1, 7'd63, "R12");
        check("R7", ac_o, 0, "glyph wrap up");
        wr(8'h0E, 1'b1, 7'd0, "R7");

        // R10 cursor moves
        cmd(8'h8A, 10, "R12");
        cmd(8'h14, 10, "R10");
        check("R10", ac_o, 11, "cursor right");
        cmd(8'h10, 10, "R10");
        check("R10", ac_o, 10, "cursor left");
        check("R10", disp_ofs_o, 0, "offset untouched by cursor");

        // R10 / R11 display shift in two-line mode
        cmd(8'h18, 10, "R10");
        check("R10", disp_ofs_o, 1, "shift left");
        cmd(8'h1C, 10, "R10");
        check("R10", disp_ofs_o, 0, "shift right");
        cmd(8'h1C, 10, "R11");
        check("R11", disp_ofs_o, 39, "two-line wrap");
        check("R10", ac_o, 10, "ac untouched by shift");

        // R4 home
        cmd(8'h02, 410, "R5");
        check("R4", {ac_o, disp_ofs_o}, 0, "home ac/offset");

        // R11 one-line wrap, R2 stray bits in shift code
        cmd(8'h30, 10, "R13");
        check("R13", two_line_o, 0, "one line");
        cmd(8'h1F, 10, "R2");
        check("R11", disp_ofs_o, 79, "one-line wrap");

        // R9 auto-shift
        cmd(8'h07, 10, "R9");
        wr(8'h61, 1'b0, 7'd0, "R9");
        check("R9", disp_ofs_o, 0, "auto shift up");
        check("R9", ac_o, 1, "ac auto shift up");
        cmd(8'h05, 10, "R9");
        wr(8'h62, 1'b0, 7'd1, "R9");
        check("R9", disp_ofs_o, 79, "auto shift down");
        cmd(8'h40, 10, "R12");
        wr(8'h33, 1'b1, 7'd0, "R9");
        check("R9", disp_ofs_o, 79, "glyph write keeps offset");
        check("R7", ac_o, 63, "glyph wrap down");

        // R3 clear
        for (int i = 0; i < 80; i++) exp_q.push_back('{1'b0, 1'b0, 7'(i), 8'h20, "R3"});
        cmd(8'h01, 410, "R5");
        check("R3", {ac_o, disp_ofs_o}, 0, "clear ac/offset");
        check("R3", {ent_inc_o, ent_shift_o}, 2'b11, "clear entry");

        // R2 home with stray bit 0
        cmd(8'h8A, 10, "R12");
        cmd(8'h03, 410, "R2");
        check("R2", ac_o, 0, "03h decodes as home");

        repeat (3) @(negedge clk);
        check("R3", exp_q.size(), 0, "pending RAM accesses");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule